// File: doc/BRIEF.md
# Debug Address Match Unit

This block watches a CPU's instruction fetch and data access streams for debug addresses. It holds a small bank of instruction breakpoint registers and a bank of data watchpoint registers. When the fetch address equals an enabled breakpoint, it raises a breakpoint request to the trap controller. When a data access falls on a watchpoint's byte address with an allowed direction, it raises a watchpoint request.

The compare path is purely combinational from the access inputs. A watchpoint request and the access-kill signal therefore appear in the same cycle as the access, before the access commits. Configuration is loaded through a one-cycle register write port. One select bit chooses the bank, and an index chooses the entry.

A debug handler flag from the core silences all matching while a debug exception is being serviced.

Top module: `dbg_match_unit`

## Requirements
- R1: Bit 0 of a breakpoint register is its enable. `brk_exc_o` is high in the same cycle as `fetch_valid_i` when some enabled breakpoint has bits [AW-1:1] equal to `fetch_pc_i[AW-1:1]`.
- R2: `brk_exc_o` stays low while `fetch_valid_i` is low.
- R3: The watchpoint kind is 2 bits: bit 0 allows reads and bit 1 allows writes. This gives 0=off, 1=read, 2=write, 3=either. A read (`dacc_write_i`=0) can hit kinds 1 and 3. A write can hit kinds 2 and 3.
- R4: A watchpoint of kind 0 never hits, whatever its address.
- R5: A watchpoint covers one byte. A hit needs every bit of `dacc_addr_i` to equal the stored address, so the neighbouring byte does not hit.
- R6: On any watchpoint hit, `dacc_block_o` is high in the same cycle as the `dacc_valid_i` access. With no breakpoint in that cycle, `wpt_exc_o` is also high. Without `dacc_valid_i`, neither is raised.
- R7: After reset every breakpoint is disabled and every watchpoint has kind 0, so no request is raised.
- R8: When a breakpoint and a watchpoint hit in the same cycle, only `brk_exc_o` is raised. `dacc_block_o` still kills the access.
- R9: While `in_debug_i` is high, `brk_exc_o`, `wpt_exc_o` and `dacc_block_o` are all low.
- R10: A configuration write takes effect from the next cycle and changes only the addressed entry. Clearing an entry that is already disabled leaves every other entry's matching unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wp_i | input | 1 | Bank select: 0 breakpoint, 1 watchpoint |
| cfg_idx_i | input | IDX_W | Entry index within the bank |
| cfg_data_i | input | AW | Breakpoint word (bit 0 enable) or watchpoint byte address |
| cfg_kind_i | input | 2 | Watchpoint kind (ignored for breakpoints) |
| fetch_valid_i | input | 1 | Fetch address valid |
| fetch_pc_i | input | AW | Fetch address |
| dacc_valid_i | input | 1 | Data access valid |
| dacc_write_i | input | 1 | Data access is a write |
| dacc_addr_i | input | AW | Data access byte address |
| in_debug_i | input | 1 | Debug exception handler active |
| brk_exc_o | output | 1 | Breakpoint exception request |
| wpt_exc_o | output | 1 | Watchpoint exception request |
| dacc_block_o | output | 1 | Suppress the current data access |

## Verification
The only state in this block is the configuration registers. A corrupt entry shows up at the first fetch or access that probes its address: a missing request, or a request on the wrong direction or neighbouring byte. No cycles of latency hide it, because the outputs follow the access inputs in the same cycle. A write landing on the wrong entry is exposed by probing the other entries right after a clear of an entry that is already disabled. The priority and debug-silencing rules are checked by stimulating a breakpoint and a watchpoint together, with the handler flag both low and high.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;
  typedef enum logic [1:0] {
    WP_OFF = 2'd0,
    WP_RD  = 2'd1,
    WP_WR  = 2'd2,
    WP_RW  = 2'd3
  } wp_kind_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
  import dbg_match_pkg::*;
#(
  parameter int unsigned NBP   = 4,
  parameter int unsigned NWP   = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned IDX_W = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic                      wp_sel_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [AW-1:0]             data_i,
  input  logic [1:0]                kind_i,
  output logic [NBP-1:0][AW-1:0]    bp_q_o,
  output logic [NWP-1:0][AW-1:0]    wp_addr_q_o,
  output wp_kind_e [NWP-1:0]        wp_kind_q_o
);
  for (genvar i = 0; i < NBP; i++) begin : g_bp
    logic sel;
    assign sel = we_i && !wp_sel_i && (idx_i == IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  bp_q_o[i] <= '0;
      else if (sel) bp_q_o[i] <= data_i;
    end
  end

  for (genvar j = 0; j < NWP; j++) begin : g_wp
    logic sel;
    assign sel = we_i && wp_sel_i && (idx_i == IDX_W'(j));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wp_addr_q_o[j] <= '0;
        wp_kind_q_o[j] <= WP_OFF;
      end else if (sel) begin
        wp_addr_q_o[j] <= data_i;
        wp_kind_q_o[j] <= wp_kind_e'(kind_i);
      end
    end
  end
endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match #(
  parameter int unsigned NBP = 4,
  parameter int unsigned AW  = 32
) (
  input  logic [NBP-1:0][AW-1:0] bp_q_i,
  input  logic                   valid_i,
  input  logic [AW-1:0]          pc_i,
  output logic [NBP-1:0]         hit_o
);
  for (genvar i = 0; i < NBP; i++) begin : g_cmp
    // bit 0 is the enable, the rest is the instruction address
    assign hit_o[i] = valid_i && bp_q_i[i][0] && (bp_q_i[i][AW-1:1] == pc_i[AW-1:1]);
  end
endmodule

// File: rtl/dbg_wp_match.sv
module dbg_wp_match
  import dbg_match_pkg::*;
#(
  parameter int unsigned NWP = 4,
  parameter int unsigned AW  = 32
) (
  input  logic [NWP-1:0][AW-1:0] addr_q_i,
  input  wp_kind_e [NWP-1:0]     kind_q_i,
  input  logic                   valid_i,
  input  logic                   write_i,
  input  logic [AW-1:0]          addr_i,
  output logic [NWP-1:0]         hit_o
);
  for (genvar j = 0; j < NWP; j++) begin : g_cmp
    logic dir_ok;
    always_comb begin
      unique case (kind_q_i[j])
        WP_RD:   dir_ok = !write_i;
        WP_WR:   dir_ok = write_i;
        WP_RW:   dir_ok = 1'b1;
        default: dir_ok = 1'b0;
      endcase
    end
    assign hit_o[j] = valid_i && dir_ok && (addr_q_i[j] == addr_i);
  end
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_match_pkg::*;
#(
  parameter int unsigned NBP   = 4,
  parameter int unsigned NWP   = 4,
  parameter int unsigned AW    = 32,
  localparam int unsigned NMAX  = (NBP > NWP) ? NBP : NWP,
  localparam int unsigned IDX_W = idx_width(NMAX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_wp_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [AW-1:0]    cfg_data_i,
  input  logic [1:0]       cfg_kind_i,
  input  logic             fetch_valid_i,
  input  logic [AW-1:0]    fetch_pc_i,
  input  logic             dacc_valid_i,
  input  logic             dacc_write_i,
  input  logic [AW-1:0]    dacc_addr_i,
  input  logic             in_debug_i,
  output logic             brk_exc_o,
  output logic             wpt_exc_o,
  output logic             dacc_block_o
);
  logic [NBP-1:0][AW-1:0] bp_q;
  logic [NWP-1:0][AW-1:0] wp_addr_q;
  wp_kind_e [NWP-1:0]     wp_kind_q;
  logic [NBP-1:0]         bp_hit;
  logic [NWP-1:0]         wp_hit;
  logic                   brk_any, wp_any;

  dbg_cfg_regs #(.NBP(NBP), .NWP(NWP), .AW(AW), .IDX_W(IDX_W)) cfg_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wp_sel_i    (cfg_wp_i),
    .idx_i       (cfg_idx_i),
    .data_i      (cfg_data_i),
    .kind_i      (cfg_kind_i),
    .bp_q_o      (bp_q),
    .wp_addr_q_o (wp_addr_q),
    .wp_kind_q_o (wp_kind_q)
  );

  dbg_bp_match #(.NBP(NBP), .AW(AW)) bpm_i (
    .bp_q_i  (bp_q),
    .valid_i (fetch_valid_i),
    .pc_i    (fetch_pc_i),
    .hit_o   (bp_hit)
  );

  dbg_wp_match #(.NWP(NWP), .AW(AW)) wpm_i (
    .addr_q_i (wp_addr_q),
    .kind_q_i (wp_kind_q),
    .valid_i  (dacc_valid_i),
    .write_i  (dacc_write_i),
    .addr_i   (dacc_addr_i),
    .hit_o    (wp_hit)
  );

  assign brk_any = (|bp_hit) && !in_debug_i;
  assign wp_any  = (|wp_hit) && !in_debug_i;

  // breakpoint wins the request; the access is killed regardless
  assign brk_exc_o    = brk_any;
  assign wpt_exc_o    = wp_any && !brk_any;
  assign dacc_block_o = wp_any;
endmodule

// File: rtl/dbg_match_chk.sv
module dbg_match_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fetch_valid_i,
  input logic dacc_valid_i,
  input logic in_debug_i,
  input logic brk_exc_o,
  input logic wpt_exc_o,
  input logic dacc_block_o
);
  AST_NO_FETCH_NO_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |-> !brk_exc_o); // R2
  AST_NO_ACC_NO_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dacc_valid_i |-> (!dacc_block_o && !wpt_exc_o)); // R6
  AST_WPT_KILLS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wpt_exc_o |-> dacc_block_o); // R6
  AST_BRK_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_exc_o |-> !wpt_exc_o); // R8
  AST_DEBUG_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_debug_i |-> !(brk_exc_o || wpt_exc_o || dacc_block_o)); // R9
  AST_ONE_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({brk_exc_o, wpt_exc_o})); // R8
endmodule

bind dbg_match_unit dbg_match_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_valid_i (fetch_valid_i),
  .dacc_valid_i  (dacc_valid_i),
  .in_debug_i    (in_debug_i),
  .brk_exc_o     (brk_exc_o),
  .wpt_exc_o     (wpt_exc_o),
  .dacc_block_o  (dacc_block_o)
);

// File: tb/dbg_match_unit_tb.sv
module dbg_match_unit_tb_top;
  localparam int unsigned AW = 32;
  localparam int unsigned N  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_wp = 0;
  logic [1:0] cfg_idx = '0;
  logic [AW-1:0] cfg_data = '0;
  logic [1:0] cfg_kind = '0;
  logic fv = 0, av = 0, aw = 0, dbg = 0;
  logic [AW-1:0] pc = '0, aa = '0;
  logic brk, wpt, blk;

  always #2.5 clk = ~clk;

  dbg_match_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wp_i(cfg_wp), .cfg_idx_i(cfg_idx),
    .cfg_data_i(cfg_data), .cfg_kind_i(cfg_kind),
    .fetch_valid_i(fv), .fetch_pc_i(pc),
    .dacc_valid_i(av), .dacc_write_i(aw), .dacc_addr_i(aa),
    .in_debug_i(dbg),
    .brk_exc_o(brk), .wpt_exc_o(wpt), .dacc_block_o(blk)
  );

  typedef struct {
    logic  brk;
    logic  wpt;
    logic  blk;
    string tag;
  } exp_t;

  exp_t scb_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  logic [AW-1:0] bp_m [N];
  logic [AW-1:0] wa_m [N];
  logic [1:0]    wk_m [N];

  task automatic cfg_write(input bit is_wp, input int idx, input logic [AW-1:0] d, input logic [1:0] k);
    @(negedge clk);
    cfg_we = 1; cfg_wp = is_wp; cfg_idx = 2'(idx); cfg_data = d; cfg_kind = k;
    if (is_wp) begin wa_m[idx] = d; wk_m[idx] = k; end
    else bp_m[idx] = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic apply(input bit f, input logic [AW-1:0] p, input bit a, input bit w,
                       input logic [AW-1:0] ad, input bit d, input string tag);
    exp_t e;
    bit b_hit, w_hit;
    @(negedge clk);
    fv = f; pc = p; av = a; aw = w; aa = ad; dbg = d;
    b_hit = 0; w_hit = 0;
    for (int i = 0; i < N; i++) begin
      if (f && bp_m[i][0] && bp_m[i][AW-1:1] == p[AW-1:1]) b_hit = 1;
      // R3 kind bit0 = read allowed, bit1 = write allowed
      if (a && wa_m[i] == ad && (w ? wk_m[i][1] : wk_m[i][0])) w_hit = 1;
    end
    if (d) begin b_hit = 0; w_hit = 0; end
    e.brk = b_hit; e.wpt = w_hit && !b_hit; e.blk = w_hit; e.tag = tag;
    scb_q.push_back(e);
  endtask

  // monitor: compares 2 ns after the falling edge, clear of the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (scb_q.size() > 0) begin
        exp_t e;
        e = scb_q.pop_front();
        checks++;
        if ({brk, wpt, blk} !== {e.brk, e.wpt, e.blk}) begin
          errors++;
          $display("FAIL %s: brk/wpt/blk actual %b%b%b expected %b%b%b",
                   e.tag, brk, wpt, blk, e.brk, e.wpt, e.blk);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin bp_m[i] = '0; wa_m[i] = '0; wk_m[i] = 2'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7 reset state: address 0 probes entries that are all zero
    apply(1, 32'h0, 1, 0, 32'h0, 0, "R7 reset read");
    apply(1, 32'h0, 1, 1, 32'h0, 0, "R7 reset write");

    cfg_write(0, 0, 32'h0000_1001, 2'd0);
    apply(1, 32'h0000_1000, 0, 0, 0, 0, "R1 bp0 hit");
    apply(1, 32'h0000_1004, 0, 0, 0, 0, "R1 bp0 other pc");
    apply(0, 32'h0000_1000, 0, 0, 0, 0, "R2 fetch invalid");
    cfg_write(0, 1, 32'h0000_2000, 2'd0);
    apply(1, 32'h0000_2000, 0, 0, 0, 0, "R1 bp1 enable bit clear");

    cfg_write(1, 0, 32'h0000_3001, 2'd1);
    apply(0, 0, 1, 0, 32'h0000_3001, 0, "R3 read wp read");
    apply(0, 0, 1, 1, 32'h0000_3001, 0, "R3 read wp write");
    apply(0, 0, 0, 0, 32'h0000_3001, 0, "R6 access invalid");
    cfg_write(1, 1, 32'h0000_4000, 2'd2);
    apply(0, 0, 1, 1, 32'h0000_4000, 0, "R3 write wp write");
    apply(0, 0, 1, 0, 32'h0000_4000, 0, "R3 write wp read");
    apply(0, 0, 1, 1, 32'h0000_4001, 0, "R5 next byte");
    apply(0, 0, 1, 1, 32'h8000_4000, 0, "R5 top bit differs");
    cfg_write(1, 2, 32'h0000_5000, 2'd3);
    apply(0, 0, 1, 0, 32'h0000_5000, 0, "R3 either read");
    apply(0, 0, 1, 1, 32'h0000_5000, 0, "R6 either write");
    cfg_write(1, 3, 32'h0000_6000, 2'd0);
    apply(0, 0, 1, 0, 32'h0000_6000, 0, "R4 off read");
    apply(0, 0, 1, 1, 32'h0000_6000, 0, "R4 off write");

    // R10 clearing entries that are already off
    cfg_write(1, 3, 32'h0, 2'd0);
    cfg_write(0, 2, 32'h0, 2'd0);
    apply(0, 0, 1, 0, 32'h0000_3001, 0, "R10 wp0 kept");
    apply(0, 0, 1, 1, 32'h0000_4000, 0, "R10 wp1 kept");
    apply(1, 32'h0000_1000, 0, 0, 0, 0, "R10 bp0 kept");
    cfg_write(0, 3, 32'hFFFF_FFFF, 2'd0);
    apply(1, 32'hFFFF_FFFE, 0, 0, 0, 0, "R1 bp3 high address");

    apply(1, 32'h0000_1000, 1, 1, 32'h0000_5000, 0, "R8 both fire");
    apply(0, 0, 1, 1, 32'h0000_5000, 0, "R6 wp alone");
    apply(1, 32'h0000_1000, 1, 1, 32'h0000_5000, 1, "R9 in debug");
    apply(1, 32'h0000_1000, 0, 0, 0, 1, "R9 in debug bp");

    cfg_write(1, 0, 32'h0000_3001, 2'd0);
    apply(0, 0, 1, 0, 32'h0000_3001, 0, "R10 wp0 removed");
    apply(0, 0, 1, 0, 32'h0000_5000, 0, "R10 wp2 untouched");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule